// File: doc/BRIEF.md
# I2C Register Target

This block is a target on a two-wire I2C bus, running at up to 400 kHz. It answers one fixed 7-bit device address and gives a bus master access to a small file of 8-bit registers. The block samples SCL and SDA with its own system clock. It passes both lines through a two-flop synchronizer and a run-length glitch filter. It then detects start, repeated start and stop conditions from SDA edges that occur while SCL is high. SDA is open-drain: the block only ever pulls it low, using an output-enable pin.

In a write transfer, the master sends the device address with the R/W bit clear and then a register pointer. One or more data bytes follow. The data bytes are held in a small pending buffer and reach the register file only when the stop condition arrives. A repeated start throws them away. To read, the master first does a dummy write that carries only the pointer. It then sends a repeated start and the device address with the R/W bit set. The block returns one byte for each master ACK and advances the pointer after each byte, until the master sends a NACK and then a stop. The register file drives a flat output bus for the logic that uses the settings. The active-low standby/reset input puts every register back to its default value.

Top module: `i2c_reg_target`

## Requirements
- R1: While rstN is low, and on the first clock after it goes low, every register on regFlat holds RESET_VAL (default 8'h00) and sdaOe is low.
- R2: A byte 1001001 followed by R/W = 0 (first byte 8'h92) after a start is acknowledged: SDA is held low during the ninth SCL high phase.
- R3: If the address byte does not match, it is not acknowledged. No later byte is acknowledged until the next start, and regFlat does not change.
- R4: The byte after a matching write address is acknowledged and becomes the register pointer, taken modulo NUM_REGS.
- R5: Write data bytes are acknowledged, but regFlat does not change until the stop condition. On the stop, the buffered bytes appear on regFlat.
- R6: In one write transfer, the k-th data byte goes to register (pointer + k) modulo NUM_REGS.
- R7: A repeated start that arrives before a stop discards all buffered write data.
- R8: After a dummy write that sets the pointer, a repeated start with the address and R/W = 1 (8'h93) is acknowledged. The block then shifts out the register at the pointer, MSB first, changing SDA only while SCL is low.
- R9: During a read, each master ACK makes the block send the register at the next pointer value (modulo NUM_REGS). After a master NACK the block releases SDA, and a stop ends the transfer.
- R10: A write transfer can buffer at most BUF_DEPTH data bytes. Any further data byte is not acknowledged and is dropped. The first BUF_DEPTH bytes still commit on the stop.
- R11: A pulse on SDA shorter than FILT_LEN system clocks (default 3) is ignored. Such a pulse while SCL is high does not abort the transfer as a false start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Active-low standby/reset; clears the register file |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level (the wired-AND bus value) |
| sdaOe | output | 1 | When high, the pad pulls SDA low |
| regFlat | output | NUM_REGS*8 | Register file, register r at bits [r*8+7:r*8] |

## Verification
The bench builds the block with NUM_REGS = 8, BUF_DEPTH = 4 and FILT_LEN = 3. With eight registers, a four-byte burst that starts at pointer 6 wraps past the top of the file, and a pointer byte of 8'h0A folds back to register 2. A depth of four lets a five-byte write reach the buffer-full NACK. A filter length of three lets a two-clock SDA pulse, one clock short of acceptance, be applied in the middle of a high SCL phase.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } busState_e;

  // strobes from control to datapath, valid for one system clock
  typedef struct packed {
    logic shiftIn;   // shift rxBit into the receive register
    logic rxBit;     // filtered SDA level
    logic loadPtr;   // received byte becomes the pointer
    logic bufPush;   // received byte goes to the pending buffer
    logic bufClear;  // drop pending writes
    logic commit;    // copy pending writes into the register file
    logic loadTx;    // load transmit register from register[pointer]
    logic shiftTx;   // advance transmit register by one bit
    logic incPtr;    // advance pointer after a read byte
  } dpCmd_t;

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineOut
);
  localparam int CNT_W = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

  logic             meta;
  logic             syncd;
  logic [CNT_W-1:0] runCnt;

  // two-flop synchronizer, then accept a new level only after it has
  // been seen for FILT_LEN consecutive clocks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta    <= 1'b1;
      syncd   <= 1'b1;
      lineOut <= 1'b1;
      runCnt  <= '0;
    end else begin
      meta  <= lineIn;
      syncd <= meta;
      if (syncd == lineOut) begin
        runCnt <= '0;
      end else if (runCnt == CNT_W'(FILT_LEN - 1)) begin
        lineOut <= syncd;
        runCnt  <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1001001
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclF,
  input  logic       sdaF,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  input  logic       bufFull,
  output dpCmd_t     cmd,
  output logic       sdaOe,
  output busState_e  stateOut
);
  localparam logic [3:0] BYTE_BITS = 4'd8;

  busState_e  state, stateNx;
  logic [3:0] bitCnt, bitCntNx;
  logic       ackOe, ackOeNx;
  logic       isRead, isReadNx;
  logic       moreRd, moreRdNx;
  logic       sclPrev, sdaPrev;
  logic       sclRise, sclFall, startEv, stopEv;

  assign sclRise = sclF & ~sclPrev;
  assign sclFall = ~sclF & sclPrev;
  assign startEv = sclF & sclPrev & sdaPrev & ~sdaF;
  assign stopEv  = sclF & sclPrev & ~sdaPrev & sdaF;

  always_comb begin
    stateNx  = state;
    bitCntNx = bitCnt;
    ackOeNx  = ackOe;
    isReadNx = isRead;
    moreRdNx = moreRd;
    cmd       = '0;
    cmd.rxBit = sdaF;

    if (startEv) begin
      stateNx      = ST_ADDR;
      bitCntNx     = '0;
      ackOeNx      = 1'b0;
      cmd.bufClear = 1'b1;
    end else if (stopEv) begin
      stateNx    = ST_IDLE;
      ackOeNx    = 1'b0;
      cmd.commit = 1'b1;
    end else begin
      case (state)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (sclRise && bitCnt < BYTE_BITS) begin
            cmd.shiftIn = 1'b1;
            bitCntNx    = bitCnt + 1'b1;
          end
          if (sclFall && bitCnt == BYTE_BITS) begin
            bitCntNx = '0;
            if (state == ST_ADDR) begin
              if (rxByte[7:1] == DEV_ADDR) begin
                stateNx  = ST_ADDR_ACK;
                ackOeNx  = 1'b1;
                isReadNx = rxByte[0];
              end else begin
                stateNx = ST_IGNORE;
              end
            end else if (state == ST_PTR) begin
              cmd.loadPtr = 1'b1;
              stateNx     = ST_PTR_ACK;
              ackOeNx     = 1'b1;
            end else begin
              stateNx = ST_WDATA_ACK;
              if (!bufFull) begin
                cmd.bufPush = 1'b1;
                ackOeNx     = 1'b1;
              end
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            ackOeNx = 1'b0;
            if (isRead) begin
              cmd.loadTx = 1'b1;
              stateNx    = ST_RDATA;
            end else begin
              stateNx = ST_PTR;
            end
          end
        end
        ST_PTR_ACK, ST_WDATA_ACK: begin
          if (sclFall) begin
            ackOeNx = 1'b0;
            stateNx = ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (sclRise && bitCnt < BYTE_BITS) begin
            bitCntNx = bitCnt + 1'b1;
          end
          if (sclFall) begin
            if (bitCnt == BYTE_BITS) begin
              stateNx  = ST_RACK;
              bitCntNx = '0;
            end else begin
              cmd.shiftTx = 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (sclRise) begin
            moreRdNx   = ~sdaF;
            cmd.incPtr = 1'b1;
          end
          if (sclFall) begin
            if (moreRd) begin
              cmd.loadTx = 1'b1;
              stateNx    = ST_RDATA;
            end else begin
              stateNx = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      ackOe   <= 1'b0;
      isRead  <= 1'b0;
      moreRd  <= 1'b0;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      state   <= stateNx;
      bitCnt  <= bitCntNx;
      ackOe   <= ackOeNx;
      isRead  <= isReadNx;
      moreRd  <= moreRdNx;
      sclPrev <= sclF;
      sdaPrev <= sdaF;
    end
  end

  assign sdaOe    = (state == ST_RDATA) ? ~txBit : ackOe;
  assign stateOut = state;
endmodule

// File: rtl/i2c_tgt_datapath.sv
module i2c_tgt_datapath
  import i2c_tgt_pkg::*;
#(
  parameter int         NUM_REGS  = 8,
  parameter int         BUF_DEPTH = 4,
  parameter logic [7:0] RESET_VAL = 8'h00
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCmd_t                cmd,
  output logic [7:0]            rxByte,
  output logic                  txBit,
  output logic                  bufFull,
  output logic [NUM_REGS*8-1:0] regFlat
);
  localparam int PTR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int CNT_W = $clog2(BUF_DEPTH + 1);
  localparam int IDX_W = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;

  logic [7:0]       rxShift;
  logic [7:0]       txShift;
  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] bufBase;
  logic [CNT_W-1:0] bufCnt;
  logic [7:0]       bufData [BUF_DEPTH];
  logic [7:0]       regFile [NUM_REGS];
  logic [7:0]       regNext [NUM_REGS];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(NUM_REGS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '1;
      ptr     <= '0;
      bufBase <= '0;
      bufCnt  <= '0;
    end else begin
      if (cmd.shiftIn) rxShift <= {rxShift[6:0], cmd.rxBit};

      if (cmd.loadPtr) begin
        ptr     <= PTR_W'(int'(rxShift) % NUM_REGS);
        bufBase <= PTR_W'(int'(rxShift) % NUM_REGS);
      end else if (cmd.bufPush || cmd.incPtr) begin
        ptr <= nextPtr(ptr);
      end

      if (cmd.bufClear || cmd.commit || cmd.loadPtr) begin
        bufCnt <= '0;
      end else if (cmd.bufPush) begin
        bufCnt <= bufCnt + 1'b1;
      end

      if (cmd.loadTx) begin
        txShift <= regFile[ptr];
      end else if (cmd.shiftTx) begin
        txShift <= {txShift[6:0], 1'b1};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cmd.bufPush) bufData[bufCnt[IDX_W-1:0]] <= rxShift;
  end

  // commit: each register takes the last pending byte aimed at it
  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) begin
      regNext[r] = regFile[r];
      if (cmd.commit) begin
        for (int k = 0; k < BUF_DEPTH; k++) begin
          if (k < int'(bufCnt) && ((int'(bufBase) + k) % NUM_REGS) == r) begin
            regNext[r] = bufData[k];
          end
        end
      end
    end
  end

  generate
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) regFile[r] <= RESET_VAL;
        else       regFile[r] <= regNext[r];
      end
      assign regFlat[r*8 +: 8] = regFile[r];
    end
  endgenerate

  assign rxByte  = rxShift;
  assign txBit   = txShift[7];
  assign bufFull = (bufCnt == CNT_W'(BUF_DEPTH));
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'b1001001,
  parameter int         NUM_REGS  = 8,
  parameter int         BUF_DEPTH = 4,
  parameter int         FILT_LEN  = 3,
  parameter logic [7:0] RESET_VAL = 8'h00
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  output logic [NUM_REGS*8-1:0] regFlat
);
  logic [1:0] lineRaw;
  logic [1:0] lineFilt;
  logic       sclFilt;
  logic       sdaFilt;
  dpCmd_t     dpCmd;
  busState_e  ctrlState;
  logic [7:0] rxByte;
  logic       txBit;
  logic       bufFull;

  assign lineRaw = {sdaIn, sclIn};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_line
      i2c_line_filter #(.FILT_LEN(FILT_LEN)) i_filt (
        .clk    (clk),
        .rstN   (rstN),
        .lineIn (lineRaw[g]),
        .lineOut(lineFilt[g])
      );
    end
  endgenerate

  assign sclFilt = lineFilt[0];
  assign sdaFilt = lineFilt[1];

  i2c_tgt_ctrl #(.DEV_ADDR(DEV_ADDR)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .sclF    (sclFilt),
    .sdaF    (sdaFilt),
    .rxByte  (rxByte),
    .txBit   (txBit),
    .bufFull (bufFull),
    .cmd     (dpCmd),
    .sdaOe   (sdaOe),
    .stateOut(ctrlState)
  );

  i2c_tgt_datapath #(
    .NUM_REGS (NUM_REGS),
    .BUF_DEPTH(BUF_DEPTH),
    .RESET_VAL(RESET_VAL)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (dpCmd),
    .rxByte (rxByte),
    .txBit  (txBit),
    .bufFull(bufFull),
    .regFlat(regFlat)
  );
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk
  import i2c_tgt_pkg::*;
#(
  parameter int         NUM_REGS  = 8,
  parameter logic [7:0] RESET_VAL = 8'h00
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclFilt,
  input logic                  sdaFilt,
  input logic                  sdaOe,
  input dpCmd_t                dpCmd,
  input busState_e             ctrlState,
  input logic [NUM_REGS*8-1:0] regFlat
);
  localparam logic [NUM_REGS*8-1:0] RESET_ALL = {NUM_REGS{RESET_VAL}};

  a_r1_standby_clears: assert property (@(posedge clk)
    !rstN |=> (regFlat == RESET_ALL && !sdaOe));

  a_r3_ignore_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_IGNORE) |-> !sdaOe);

  a_r5_regs_move_on_commit: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(regFlat) |-> $past(dpCmd.commit));

  a_r5_commit_on_stop: assert property (@(posedge clk) disable iff (!rstN)
    dpCmd.commit |-> (sclFilt && $rose(sdaFilt)));

  a_r8_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclFilt);
endmodule

bind i2c_reg_target i2c_reg_target_chk #(
  .NUM_REGS (NUM_REGS),
  .RESET_VAL(RESET_VAL)
) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sclFilt  (sclFilt),
  .sdaFilt  (sdaFilt),
  .sdaOe    (sdaOe),
  .dpCmd    (dpCmd),
  .ctrlState(ctrlState),
  .regFlat  (regFlat)
);

// File: tb/test_i2c_reg_target.sv
module test_i2c_reg_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 25;   // quarter SCL period in system clocks
  localparam int NREG       = 8;
  localparam int BUFD       = 4;
  localparam int FILT       = 3;
  localparam logic [6:0] DEV = 7'b1001001;

  typedef struct packed {
    logic [7:0] ptr;
    logic [7:0] data;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{ptr: 8'h00, data: 8'hA5},
    '{ptr: 8'h03, data: 8'h3C},
    '{ptr: 8'h07, data: 8'hFF},
    '{ptr: 8'h0A, data: 8'h81},
    '{ptr: 8'h05, data: 8'h6E},
    '{ptr: 8'h01, data: 8'h5A}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic sdaOe;
  logic sdaBus;
  logic [NREG*8-1:0] regFlat;

  int   nRun = 0;
  int   nFail = 0;
  bit   finished = 0;
  logic [7:0] mdl [NREG];

  assign sdaBus = mSda & ~sdaOe;
  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_reg_target #(
    .DEV_ADDR(DEV), .NUM_REGS(NREG), .BUF_DEPTH(BUFD), .FILT_LEN(FILT), .RESET_VAL(8'h00)
  ) i_i2c_reg_target (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus), .sdaOe(sdaOe), .regFlat(regFlat)
  );

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic checkAll(input string req);
    for (int r = 0; r < NREG; r++) check(req, "register contents", regFlat[r*8 +: 8], mdl[r]);
  endtask

  task automatic busStart;
    mSda = 1'b1; tick(Q);
    mScl = 1'b1; tick(Q);
    mSda = 1'b0; tick(Q);
    mScl = 1'b0; tick(Q);
  endtask

  task automatic busStop;
    mSda = 1'b0; tick(Q);
    mScl = 1'b1; tick(Q);
    mSda = 1'b1; tick(2*Q);
  endtask

  task automatic sendByte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; tick(Q);
      mScl = 1'b1; tick(Q);
      if (glitch && b[i]) begin
        mSda = 1'b0; tick(FILT - 1);
        mSda = 1'b1; tick(Q - (FILT - 1));
      end else begin
        tick(Q);
      end
      mScl = 1'b0; tick(Q);
    end
    mSda = 1'b1; tick(Q);
    mScl = 1'b1; tick(Q);
    ack = !sdaBus;
    tick(Q);
    mScl = 1'b0; tick(Q);
  endtask

  task automatic recvByte(input bit nack, output logic [7:0] b);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      mScl = 1'b1; tick(Q);
      b[i] = sdaBus;
      tick(Q);
      mScl = 1'b0;
    end
    mSda = nack; tick(Q);
    mScl = 1'b1; tick(2*Q);
    mScl = 1'b0; tick(Q);
    mSda = 1'b1;
  endtask

  task automatic setPtr(input logic [7:0] p, input string req);
    bit a;
    busStart;
    sendByte({DEV, 1'b0}, 1'b0, a); check("R2", "write address ack", a, 1);
    sendByte(p, 1'b0, a);           check(req, "pointer ack", a, 1);
  endtask

  task automatic readSeq(input logic [7:0] p, input int n, input string req);
    bit a;
    logic [7:0] d;
    setPtr(p, "R4");
    busStart;
    sendByte({DEV, 1'b1}, 1'b0, a); check("R8", "read address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      recvByte(k == n - 1, d);
      check(req, "read data", d, mdl[(int'(p) + k) % NREG]);
    end
    busStop;
    check(req, "SDA released after read", sdaOe, 0);
  endtask

  initial begin
    bit a;
    for (int r = 0; r < NREG; r++) mdl[r] = 8'h00;
    tick(5);
    // R1: reset state
    checkAll("R1");
    check("R1", "sdaOe in reset", sdaOe, 0);
    rstN = 1'b1;
    tick(10);

    // table walk: single-byte write, hold until stop, read back
    for (int v = 0; v < 6; v++) begin
      int idx;
      idx = int'(VECS[v].ptr) % NREG;
      setPtr(VECS[v].ptr, "R4");
      sendByte(VECS[v].data, 1'b0, a);
      check("R5", "data ack", a, 1);
      check("R5", "register unchanged before stop", regFlat[idx*8 +: 8], mdl[idx]);
      busStop;
      mdl[idx] = VECS[v].data;
      checkAll("R5");
      readSeq(VECS[v].ptr, 1, "R8");
    end

    // R6: burst write wraps around the top of the file
    setPtr(8'h06, "R4");
    for (int k = 0; k < 4; k++) begin
      sendByte(8'h11 * (k + 1), 1'b0, a);
      check("R6", "burst data ack", a, 1);
    end
    checkAll("R5");
    busStop;
    for (int k = 0; k < 4; k++) mdl[(6 + k) % NREG] = 8'(8'h11 * (k + 1));
    checkAll("R6");

    // R10: fifth byte beyond the buffer is refused and dropped
    setPtr(8'h02, "R4");
    for (int k = 0; k < 5; k++) begin
      sendByte(8'hA1 + 8'(k), 1'b0, a);
      check("R10", "buffer limit ack", a, (k < BUFD) ? 1 : 0);
    end
    busStop;
    for (int k = 0; k < BUFD; k++) mdl[2 + k] = 8'hA1 + 8'(k);
    checkAll("R10");

    // R9: sequential read with wrap, NACK on the last byte
    readSeq(8'h06, 4, "R9");

    // R3: wrong address is ignored until the next start
    busStart;
    sendByte({7'b1001000, 1'b0}, 1'b0, a); check("R3", "foreign address ack", a, 0);
    sendByte(8'h01, 1'b0, a);              check("R3", "ignored byte ack", a, 0);
    sendByte(8'hEE, 1'b0, a);              check("R3", "ignored byte ack", a, 0);
    busStop;
    checkAll("R3");

    // R7: repeated start drops pending data
    setPtr(8'h00, "R4");
    sendByte(8'h99, 1'b0, a); check("R7", "pending data ack", a, 1);
    busStart;
    sendByte({DEV, 1'b0}, 1'b0, a); check("R7", "address after restart", a, 1);
    sendByte(8'h04, 1'b0, a);       check("R7", "pointer after restart", a, 1);
    sendByte(8'h77, 1'b0, a);       check("R7", "data after restart", a, 1);
    busStop;
    mdl[4] = 8'h77;
    check("R7", "discarded write to register 0", regFlat[7:0], mdl[0]);
    checkAll("R7");

    // R11: short SDA pulses while SCL is high are filtered
    busStart;
    sendByte({DEV, 1'b0}, 1'b1, a); check("R11", "address ack with glitches", a, 1);
    sendByte(8'h03, 1'b1, a);       check("R11", "pointer ack with glitches", a, 1);
    sendByte(8'hC3, 1'b1, a);       check("R11", "data ack with glitches", a, 1);
    busStop;
    mdl[3] = 8'hC3;
    checkAll("R11");

    // R1: standby clears the register file
    rstN = 1'b0;
    tick(3);
    for (int r = 0; r < NREG; r++) mdl[r] = 8'h00;
    checkAll("R1");
    check("R1", "sdaOe in standby", sdaOe, 0);
    rstN = 1'b1;
    tick(10);
    readSeq(8'h03, 1, "R1");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule